// File: doc/BRIEF.md
# Erase, Program and Verify Sequencer for Byte-Wide Reprogrammable Memory

This controller takes a byte-wide, electrically erasable memory that is reprogrammed off-line through a full rewrite. The memory is driven through its chip-enable, output-enable and program-strobe pins. A run erases the whole array with one long strobe while the address-9 supervoltage and the programming voltage are on. It then reads every location and demands 0xFF. Next it writes the source image one byte per strobe with the programming voltage on, and ends with a second full read pass that compares each location against the image.

There is no status polling and no retry. Both erase and program are fixed-width, open-loop pulses, so the read passes are the only proof that they worked. Every delay is a cycle count given by a parameter. Those delays are: the power-up wait, the erase and program pulse widths, the setup and hold margins around each pulse, the recovery time after the high voltages drop, and the read sampling delay. The last address is also a parameter, so one build serves parts of different sizes. The source image is read through a simple combinational lookup: the controller puts out an address and receives the byte for it.

Top module: `mtp_reprogrammer`

## Requirements
- R1: After reset the block stays busy for T_PWRUP cycles, holds every enable inactive and ignores `start`. It then goes idle with pass and fail both low.
- R2: Erase raises `vpp_en` and `a9_hv_en` and holds `mem_ce_n` low and `mem_oe_n` high for T_SETUP cycles. It then drives `mem_pgm_n` low for exactly T_ERASE cycles and keeps both high voltages on for T_HOLD cycles after the strobe. There is exactly one erase strobe per run.
- R3: `mem_oe_n` never goes low while either high-voltage enable is on. At least T_RECOV cycles with both enables off pass before a read pass starts.
- R4: The blank check reads addresses 0 to LAST_ADDR in ascending order with `mem_ce_n` and `mem_oe_n` low, sampling each byte T_SAMPLE cycles after its address is presented. Any byte other than 0xFF fails the run.
- R5: Programming issues one strobe per address in ascending order from 0 to LAST_ADDR. Each strobe lasts exactly T_PROG cycles, with `vpp_en` on, `a9_hv_en` off and `mem_oe_n` high.
- R6: Around each program strobe, the address, the driven data and `vpp_en` are steady for at least T_SETUP cycles before the strobe falls and for T_HOLD cycles after it rises.
- R7: After programming, the final pass reads every address and compares it with `img_data` for that address. On a clean device, the memory then holds the image.
- R8: The first mismatch in either read pass stops the run. `fail_addr` and `fail_data` capture that address and the byte read, `fail` rises, `busy` falls, all enables go inactive, and no later pass or strobe takes place.
- R9: A run in which every comparison matches ends with `pass` high, `fail` low and `busy` low.
- R10: A `start` pulse while idle, passed or failed begins a new run and clears the previous result. A `start` pulse during a run has no effect.
- R11: `mem_dq_oe` is high only while `mem_oe_n` is high, and only within the program phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| busy | output | 1 | Power-up wait or run in progress |
| pass | output | 1 | Last run verified completely |
| fail | output | 1 | Last run stopped on a mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_data | output | 8 | Byte read at the first mismatch |
| img_addr | output | ADDR_W | Address presented to the image source |
| img_data | input | 8 | Image byte for `img_addr` |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | 8 | Data driven to the memory while programming |
| mem_dq_oe | output | 1 | Enable for the `mem_dq_out` driver |
| mem_dq_in | input | 8 | Data read from the memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_pgm_n | output | 1 | Erase/program strobe, active low |
| vpp_en | output | 1 | Programming-voltage switch enable |
| a9_hv_en | output | 1 | Address-9 supervoltage switch enable |

## Verification
The hardest case to reach is a run that clears the blank check and then fails only on read-back after programming. Reaching it needs a device that erases correctly but will not clear one particular bit. The bench's behavioural memory gets a per-address stuck-at-one mask for this, and the image byte at that address is chosen with the stuck bit clear. Stuck-at-zero masks at an interior address and at the last address produce blank-check failures. A `start` pulse in the middle of programming tests that requests are ignored while a run is in progress.

// File: rtl/mtp_reprogrammer.sv
module mtp_reprogrammer #(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] LAST_ADDR = '1,
  parameter int T_PWRUP = 5000,
  parameter int T_ERASE = 5000000,
  parameter int T_PROG = 1000,
  parameter int T_SETUP = 50,
  parameter int T_HOLD = 50,
  parameter int T_RECOV = 50,
  parameter int T_SAMPLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_data,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [7:0]        img_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [7:0]        mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pgm_n,
  output logic              vpp_en,
  output logic              a9_hv_en
);
  localparam int T_M1 = (T_ERASE > T_PWRUP) ? T_ERASE : T_PWRUP;
  localparam int T_M2 = (T_PROG > T_SETUP) ? T_PROG : T_SETUP;
  localparam int T_M3 = (T_HOLD > T_RECOV) ? T_HOLD : T_RECOV;
  localparam int T_M4 = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_M5 = (T_M3 > T_SAMPLE) ? T_M3 : T_SAMPLE;
  localparam int T_MAX = (T_M4 > T_M5) ? T_M4 : T_M5;
  localparam int CNT_W = $clog2(T_MAX + 1);

  typedef enum logic [3:0] {
    ST_PWR, ST_IDLE, ST_E_SET, ST_E_PULSE, ST_E_HOLD, ST_E_REC, ST_VERIFY,
    ST_P_SET, ST_P_PULSE, ST_P_HOLD, ST_P_REC, ST_DONE, ST_FAIL
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic              chk_img;
  logic              tick, at_last, erase_hv, prog_hv, rest;
  logic [7:0]        expect_byte;

  assign tick        = (cnt == '0);
  assign at_last     = (addr == LAST_ADDR);
  assign rest        = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
  assign erase_hv    = (state == ST_E_SET) || (state == ST_E_PULSE) || (state == ST_E_HOLD);
  assign prog_hv     = (state == ST_P_SET) || (state == ST_P_PULSE) || (state == ST_P_HOLD);
  assign expect_byte = chk_img ? img_data : 8'hFF;

  assign busy       = !rest;
  assign vpp_en     = erase_hv || prog_hv;
  assign a9_hv_en   = erase_hv;
  assign mem_ce_n   = rest || (state == ST_PWR);
  assign mem_oe_n   = (state != ST_VERIFY);
  assign mem_pgm_n  = !((state == ST_E_PULSE) || (state == ST_P_PULSE));
  assign mem_dq_oe  = prog_hv;
  assign mem_dq_out = img_data;
  assign mem_addr   = addr;
  assign img_addr   = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PWR;
      cnt       <= CNT_W'(T_PWRUP - 1);
      addr      <= '0;
      chk_img   <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_data <= '0;
    end else begin
      if (!tick) cnt <= cnt - 1'b1;
      case (state)
        ST_PWR: if (tick) state <= ST_IDLE;
        ST_IDLE, ST_DONE, ST_FAIL:
          if (start) begin
            state     <= ST_E_SET;
            cnt       <= CNT_W'(T_SETUP - 1);
            addr      <= '0;
            chk_img   <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
          end
        ST_E_SET:   if (tick) begin state <= ST_E_PULSE; cnt <= CNT_W'(T_ERASE - 1); end
        ST_E_PULSE: if (tick) begin state <= ST_E_HOLD;  cnt <= CNT_W'(T_HOLD - 1);  end
        ST_E_HOLD:  if (tick) begin state <= ST_E_REC;   cnt <= CNT_W'(T_RECOV - 1); end
        ST_E_REC, ST_P_REC:
          if (tick) begin
            state   <= ST_VERIFY;
            cnt     <= CNT_W'(T_SAMPLE - 1);
            addr    <= '0;
            chk_img <= (state == ST_P_REC);
          end
        ST_VERIFY:
          if (tick) begin
            if (mem_dq_in != expect_byte) begin
              state     <= ST_FAIL;
              fail      <= 1'b1;
              fail_addr <= addr;
              fail_data <= mem_dq_in;
            end else if (!at_last) begin
              addr <= addr + 1'b1;
              cnt  <= CNT_W'(T_SAMPLE - 1);
            end else if (chk_img) begin
              state <= ST_DONE;
              pass  <= 1'b1;
            end else begin
              state <= ST_P_SET;
              addr  <= '0;
              cnt   <= CNT_W'(T_SETUP - 1);
            end
          end
        ST_P_SET:   if (tick) begin state <= ST_P_PULSE; cnt <= CNT_W'(T_PROG - 1); end
        ST_P_PULSE: if (tick) begin state <= ST_P_HOLD;  cnt <= CNT_W'(T_HOLD - 1); end
        ST_P_HOLD:
          if (tick) begin
            if (at_last) begin
              state <= ST_P_REC;
              cnt   <= CNT_W'(T_RECOV - 1);
            end else begin
              state <= ST_P_SET;
              addr  <= addr + 1'b1;
              cnt   <= CNT_W'(T_SETUP - 1);
            end
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_strobe_needs_vpp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> vpp_en && mem_oe_n);

  p_read_without_hv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !vpp_en && !a9_hv_en && !mem_dq_oe);

  p_addr_steady_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |=> mem_pgm_n || $stable(mem_addr));

  p_idle_hv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !vpp_en && !a9_hv_en && mem_pgm_n && mem_oe_n);

  p_result_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  p_drive_only_programming_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> vpp_en && !a9_hv_en);
endmodule

// File: tb/tb_mtp_reprogrammer.sv
module tb_mtp_reprogrammer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int LAST = 15;
  localparam int T_PWRUP = 20, T_ERASE = 30, T_PROG = 6, T_SETUP = 2;
  localparam int T_HOLD = 2, T_RECOV = 3, T_SAMPLE = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, pass, fail, mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n, vpp_en, a9_hv_en;
  logic [AW-1:0] fail_addr, img_addr, mem_addr;
  logic [7:0] fail_data, img_data, mem_dq_out, mem_dq_in;

  logic [7:0] mem [0:LAST];
  logic [7:0] img [0:LAST];
  logic [7:0] s0 [0:LAST];
  logic [7:0] s1 [0:LAST];

  int nvec = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign img_data  = img[img_addr];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? ((mem[mem_addr] & ~s0[mem_addr]) | s1[mem_addr]) : 8'h00;

  mtp_reprogrammer #(.ADDR_W(AW), .LAST_ADDR(AW'(LAST)), .T_PWRUP(T_PWRUP), .T_ERASE(T_ERASE),
    .T_PROG(T_PROG), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_RECOV(T_RECOV), .T_SAMPLE(T_SAMPLE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_data(fail_data), .img_addr(img_addr), .img_data(img_data),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n), .vpp_en(vpp_en), .a9_hv_en(a9_hv_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural device plus per-clock protocol reference
  logic prev_pgm_n = 1, prev_oe_n = 1, pulse_a9 = 0, pulse_vpp = 0;
  logic [AW-1:0] prev_addr = '0, pulse_addr = '0;
  logic [7:0] prev_dq = '0, pulse_dq = '0;
  int addr_age = 0, vpp_age = 0, hvoff_age = 0, low_cnt = 0, hold_left = 0;
  int erase_cnt = 0, prog_cnt = 0, prog_expect = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      addr_age  = (mem_addr == prev_addr && (!mem_dq_oe || mem_dq_out == prev_dq)) ? addr_age + 1 : 0;
      vpp_age   = vpp_en ? vpp_age + 1 : 0;
      hvoff_age = (!vpp_en && !a9_hv_en) ? hvoff_age + 1 : 0;
      chk(!(!mem_oe_n && (vpp_en || a9_hv_en)), "R3 read with high voltage", vpp_en, 0);
      chk(!(mem_dq_oe && !mem_oe_n), "R11 bus contention", mem_dq_oe, 0);
      chk(busy || (!vpp_en && !a9_hv_en && mem_pgm_n), "R8 enables while not busy", vpp_en, 0);
      chk(!(pass && fail), "R9 pass and fail together", pass, 0);
      if (!mem_oe_n && prev_oe_n)
        chk(hvoff_age > T_RECOV, "R3 recovery before read", hvoff_age - 1, T_RECOV);
      if (!mem_pgm_n && prev_pgm_n) begin
        low_cnt = 0;
        pulse_a9 = a9_hv_en; pulse_vpp = vpp_en; pulse_addr = mem_addr; pulse_dq = mem_dq_out;
        chk(vpp_age > T_SETUP, "R2 R6 voltage setup", vpp_age - 1, T_SETUP);
        if (!a9_hv_en) begin
          chk(addr_age >= T_SETUP && mem_dq_oe, "R6 address/data setup", addr_age, T_SETUP);
          chk(int'(mem_addr) == prog_expect, "R5 program order", mem_addr, prog_expect);
          prog_expect++;
        end else begin
          chk(mem_oe_n && !mem_ce_n, "R2 erase control levels", mem_oe_n, 1);
        end
      end
      if (!mem_pgm_n) begin
        low_cnt++;
        chk(vpp_en && mem_oe_n, "R5 strobe without voltage", vpp_en, 1);
      end
      if (mem_pgm_n && !prev_pgm_n) begin
        hold_left = T_HOLD;
        if (pulse_a9) begin
          chk(low_cnt == T_ERASE, "R2 erase width", low_cnt, T_ERASE);
          erase_cnt++;
          if (pulse_vpp) for (int a = 0; a <= LAST; a++) mem[a] = 8'hFF;
        end else begin
          chk(low_cnt == T_PROG, "R5 program width", low_cnt, T_PROG);
          prog_cnt++;
          if (pulse_vpp) mem[pulse_addr] = mem[pulse_addr] & pulse_dq;
        end
      end
      if (hold_left > 0) begin
        chk(mem_addr == pulse_addr && vpp_en && (pulse_a9 || mem_dq_out == pulse_dq),
            "R6 hold after strobe", mem_addr, pulse_addr);
        hold_left--;
      end
      prev_pgm_n = mem_pgm_n; prev_oe_n = mem_oe_n; prev_addr = mem_addr; prev_dq = mem_dq_out;
    end
  end

  task automatic do_run(input bit poke);
    int exp_fail = 0, exp_addr = 0;
    logic [7:0] exp_data = 0, rd;
    int guard = 0;
    bit found = 0;
    erase_cnt = 0; prog_cnt = 0; prog_expect = 0;
    for (int a = 0; a <= LAST; a++) begin
      rd = (8'hFF & ~s0[a]) | s1[a];
      if (!found && rd != 8'hFF) begin found = 1; exp_addr = a; exp_data = rd; end
    end
    if (!found)
      for (int a = 0; a <= LAST; a++) begin
        rd = (img[a] & ~s0[a]) | s1[a];
        if (!found && rd != img[a]) begin found = 1; exp_addr = a; exp_data = rd; end
      end
    exp_fail = found;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R10 start accepted", busy, 1);
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
      start = (poke && guard == 150);
    end
    start = 0;
    chk(guard < 20000, "watchdog run", guard, 20000);
    chk(fail == exp_fail, exp_fail ? "R8 fail flag" : "R9 fail flag", fail, exp_fail);
    chk(pass == !exp_fail, "R9 pass flag", pass, !exp_fail);
    chk(!vpp_en && !a9_hv_en && mem_pgm_n && mem_oe_n, "R8 outputs quiet", vpp_en, 0);
    chk(erase_cnt == 1, "R2 R10 erase strobes", erase_cnt, 1);
    if (exp_fail) begin
      chk(int'(fail_addr) == exp_addr, "R8 fail_addr", fail_addr, exp_addr);
      chk(fail_data == exp_data, "R8 fail_data", fail_data, exp_data);
    end
    if (exp_fail && ((8'hFF & ~s0[exp_addr]) | s1[exp_addr]) != 8'hFF)
      chk(prog_cnt == 0, "R4 R8 no program after blank fail", prog_cnt, 0);
    else
      chk(prog_cnt == LAST + 1, "R5 program strobes", prog_cnt, LAST + 1);
    if (!exp_fail)
      for (int a = 0; a <= LAST; a++)
        chk(mem[a] == img[a], "R7 contents", mem[a], img[a]);
  endtask

  initial begin
    int cyc = 0;
    for (int a = 0; a <= LAST; a++) begin
      mem[a] = 8'h5A; s0[a] = 0; s1[a] = 0; img[a] = 8'((a * 37 + 11) ^ 8'hC3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    chk(busy == 1, "R1 busy after reset", busy, 1);
    chk(!vpp_en && !a9_hv_en && mem_pgm_n && mem_oe_n && mem_ce_n, "R1 enables off", vpp_en, 0);
    start = 1;
    @(negedge clk) start = 0;
    cyc = 1;
    while (busy && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(cyc >= T_PWRUP - 1 && cyc <= T_PWRUP + 1, "R1 power-up wait", cyc, T_PWRUP);
    chk(!pass && !fail, "R1 R10 start ignored in power-up", pass | fail, 0);
    repeat (3) @(negedge clk);
    chk(!busy, "R1 idle after power-up", busy, 0);

    do_run(1);                                   // clean pass with mid-run start (R9, R10)
    s0[5] = 8'h08;                               // blank check fails at 5 (R4, R8)
    do_run(0);
    s0[5] = 0; s0[LAST] = 8'h01;                 // blank check fails at last address (R4)
    do_run(0);
    s0[LAST] = 0; img[9] = 8'h3C; s1[9] = 8'h80; // read-back fails at 9 (R7, R8)
    do_run(0);
    s1[9] = 0;
    for (int a = 0; a <= LAST; a++) img[a] = 8'(a * 16 + 15 - a);
    do_run(0);                                   // restart after fail, new image (R10)

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nvec++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule